// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block carries out one bit of a non-restoring division per operation. It keeps three flag bits: Q (the last remainder sign), M (the divisor sign) and T (the quotient bit), and it produces the next partial remainder. Software or a sequencer picks one operation per cycle. The unsigned-clear operation zeroes the flags before an unsigned divide. The signed-setup operation loads the flags from the signs of dividend and divisor. The step operation shifts the old T into the remainder and then adds or subtracts the divisor.

The caller owns the remainder register. It presents the remainder on `rnIn` and the divisor on `rmIn`, and it takes the updated remainder back from `rnOut`. The caller also rotates the quotient through T in a register of its own, and it writes T back with the load-T operation. The caller sequences the steps (32 for a 32-bit divide) and corrects the remainder at the end.

Top module: `divstep_unit`

## Requirements
- R1: While `rstN` is low, and after it is released, `rnOut`, `qFlag`, `mFlag` and `tFlag` all read 0.
- R2: `opSel` = 3'b001 (unsigned clear) sets Q, M and T to 0 and leaves `rnOut` unchanged.
- R3: `opSel` = 3'b010 (signed setup) sets Q to `rnIn` bit DATA_W-1, M to `rmIn` bit DATA_W-1 and T to Q XOR M, and leaves `rnOut` unchanged.
- R4: On `opSel` = 3'b011 (step), the operand to the adder is `rnIn` shifted left by one, with the old T placed in bit 0.
- R5: During a step, if the old Q equals M the divisor `rmIn` is subtracted from the shifted value. Otherwise the divisor is added. The result, modulo 2^DATA_W, appears on `rnOut`.
- R6: After a step, Q equals the old `rnIn` bit DATA_W-1 XOR M XOR c. Here c is the carry out of the add, or the borrow of the subtract. A carry is present exactly when the result is below the shifted value. A borrow is present exactly when the result is above the shifted value.
- R7: After a step, T is 1 exactly when the new Q equals M, and M is unchanged.
- R8: `opSel` = 3'b100 (load T) copies `tIn` into T and leaves Q, M and `rnOut` unchanged.
- R9: `opSel` values 3'b000, 3'b101, 3'b110 and 3'b111 change none of `rnOut`, `qFlag`, `mFlag` or `tFlag`.
- R10: Every operation takes effect at the first rising clock edge after it is presented, and the outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 3 | Operation select (see R2, R3, R4, R8, R9) |
| rnIn | input | DATA_W | Dividend or current partial remainder |
| rmIn | input | DATA_W | Divisor |
| tIn | input | 1 | Value written into T by the load-T operation |
| rnOut | output | DATA_W | Partial remainder after the last step |
| qFlag | output | 1 | Q flag |
| mFlag | output | 1 | M flag |
| tFlag | output | 1 | T flag (quotient bit) |

## Verification
In one step edge, T is both read and written. The old T is shifted into bit 0 of the remainder, and the new T is produced from the new Q. The bench provokes this by running full 32-step unsigned divisions in which a load-T edge comes right before every step edge. Each quotient is judged against integer division, including divisor 1 and dividend 0xFFFFFFFF. A bench model that tests carry and borrow by magnitude comparison checks every intermediate remainder and flag set, and a quotient is only correct if the shift-in and the flag update use the right T on every step.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'b000,
    OP_CLRU = 3'b001,
    OP_SGN  = 3'b010,
    OP_STEP = 3'b011,
    OP_LDT  = 3'b100
  } divOp_e;

  typedef struct packed {
    logic clrFlags;
    logic setSigned;
    logic doStep;
    logic loadT;
  } divStrobe_t;

endpackage

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
  import divstep_pkg::*;
(
  input  logic [2:0] opSel,
  output divStrobe_t strb
);

  always_comb begin
    strb = '0;
    unique case (opSel)
      OP_CLRU: strb.clrFlags  = 1'b1;
      OP_SGN:  strb.setSigned = 1'b1;
      OP_STEP: strb.doStep    = 1'b1;
      OP_LDT:  strb.loadT     = 1'b1;
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              addMode,
  output logic [DATA_W-1:0] result,
  output logic              carryOrBorrow
);

  logic [DATA_W-1:0] operandB;
  logic [DATA_W:0]   wideSum;

  // subtract is done as A + ~B + 1; the carry out then means "no borrow"
  assign operandB = addMode ? opB : ~opB;
  assign wideSum  = {1'b0, opA} + {1'b0, operandB} + {{DATA_W{1'b0}}, ~addMode};
  assign result   = wideSum[DATA_W-1:0];
  assign carryOrBorrow = addMode ? wideSum[DATA_W] : ~wideSum[DATA_W];

endmodule

// File: rtl/divstep_dp.sv
module divstep_dp
  import divstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strb,
  input  logic [DATA_W-1:0] rnIn,
  input  logic [DATA_W-1:0] rmIn,
  input  logic              tIn,
  output logic [DATA_W-1:0] rnOut,
  output logic              qFlag,
  output logic              mFlag,
  output logic              tFlag
);

  localparam int MSB = DATA_W - 1;

  logic              addMode;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] stepResult;
  logic              carryOrBorrow;
  logic              qNext;

  assign addMode = qFlag ^ mFlag;
  assign shifted = {rnIn[MSB-1:0], tFlag};

  divstep_addsub #(.DATA_W(DATA_W)) addsubInst (
    .opA           (shifted),
    .opB           (rmIn),
    .addMode       (addMode),
    .result        (stepResult),
    .carryOrBorrow (carryOrBorrow)
  );

  assign qNext = rnIn[MSB] ^ mFlag ^ carryOrBorrow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rnOut <= '0;
      qFlag <= 1'b0;
      mFlag <= 1'b0;
      tFlag <= 1'b0;
    end else if (strb.clrFlags) begin
      qFlag <= 1'b0;
      mFlag <= 1'b0;
      tFlag <= 1'b0;
    end else if (strb.setSigned) begin
      qFlag <= rnIn[MSB];
      mFlag <= rmIn[MSB];
      tFlag <= rnIn[MSB] ^ rmIn[MSB];
    end else if (strb.doStep) begin
      rnOut <= stepResult;
      qFlag <= qNext;
      tFlag <= (qNext == mFlag);
    end else if (strb.loadT) begin
      tFlag <= tIn;
    end
  end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] rnIn,
  input  logic [DATA_W-1:0] rmIn,
  input  logic              tIn,
  output logic [DATA_W-1:0] rnOut,
  output logic              qFlag,
  output logic              mFlag,
  output logic              tFlag
);

  divStrobe_t strb;

  divstep_ctrl ctrlInst (
    .opSel (opSel),
    .strb  (strb)
  );

  divstep_dp #(.DATA_W(DATA_W)) dpInst (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rnIn  (rnIn),
    .rmIn  (rmIn),
    .tIn   (tIn),
    .rnOut (rnOut),
    .qFlag (qFlag),
    .mFlag (mFlag),
    .tFlag (tFlag)
  );

endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] rnIn,
  input logic [DATA_W-1:0] rmIn,
  input logic              tIn,
  input logic [DATA_W-1:0] rnOut,
  input logic              qFlag,
  input logic              mFlag,
  input logic              tFlag
);

  // R2
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'b001 |=> (!qFlag && !mFlag && !tFlag && $stable(rnOut)));

  // R3
  signed_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'b010 |=> (qFlag == $past(rnIn[DATA_W-1])) &&
                        (mFlag == $past(rmIn[DATA_W-1])) &&
                        (tFlag == (qFlag ^ mFlag)) && $stable(rnOut));

  // R7
  step_tflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'b011 |=> (tFlag == (qFlag == mFlag)) && $stable(mFlag));

  // R8
  load_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'b100 |=> (tFlag == $past(tIn)) && $stable(qFlag) &&
                        $stable(mFlag) && $stable(rnOut));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'b000 || opSel[2:1] == 2'b11 || opSel == 3'b101) |=>
      $stable(rnOut) && $stable(qFlag) && $stable(mFlag) && $stable(tFlag));

endmodule

bind divstep_unit divstep_chk #(.DATA_W(DATA_W)) chkInst (
  .clk   (clk),
  .rstN  (rstN),
  .opSel (opSel),
  .rnIn  (rnIn),
  .rmIn  (rmIn),
  .tIn   (tIn),
  .rnOut (rnOut),
  .qFlag (qFlag),
  .mFlag (mFlag),
  .tFlag (tFlag)
);

// File: tb/tb_divstep_unit.sv
module tb_divstep_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   opSel = 3'b000;
  logic [W-1:0] rnIn = '0;
  logic [W-1:0] rmIn = '0;
  logic         tIn = 1'b0;
  logic [W-1:0] rnOut;
  logic         qFlag, mFlag, tFlag;

  int checks = 0;
  int fails = 0;

  logic [W-1:0] mRn = '0;
  logic         mQ = 1'b0, mM = 1'b0, mT = 1'b0;

  divstep_unit #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .rnIn(rnIn), .rmIn(rmIn),
    .tIn(tIn), .rnOut(rnOut), .qFlag(qFlag), .mFlag(mFlag), .tFlag(tFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference step, carry/borrow judged by magnitude of the result
  task automatic refStep(input logic [W-1:0] rn, input logic [W-1:0] rm);
    logic [W-1:0] sh, res;
    logic cb, qn;
    sh = {rn[W-2:0], mT};
    if (mQ == mM) begin
      res = sh - rm;
      cb = (res > sh);
    end else begin
      res = sh + rm;
      cb = (res < sh);
    end
    qn = rn[W-1] ^ mM ^ cb;
    mRn = res;
    mQ = qn;
    mT = (qn == mM);
  endtask

  task automatic runOp(input logic [2:0] op, input logic [W-1:0] rn,
                       input logic [W-1:0] rm, input logic tv, input string req);
    @(negedge clk);
    opSel = op; rnIn = rn; rmIn = rm; tIn = tv;
    #1;
    check("R10 before edge", {rnOut, qFlag, mFlag, tFlag}, {mRn, mQ, mM, mT});
    case (op)
      3'b001: begin mQ = 1'b0; mM = 1'b0; mT = 1'b0; end
      3'b010: begin mQ = rn[W-1]; mM = rm[W-1]; mT = rn[W-1] ^ rm[W-1]; end
      3'b011: refStep(rn, rm);
      3'b100: mT = tv;
      default: ;
    endcase
    @(posedge clk);
    #1;
    check(req, {rnOut, qFlag, mFlag, tFlag}, {mRn, mQ, mM, mT});
    opSel = 3'b000;
  endtask

  task automatic divide(input logic [W-1:0] n, input logic [W-1:0] d);
    logic [W-1:0] rem, quo;
    logic tv;
    runOp(3'b001, '0, '0, 1'b0, "R2 unsigned clear");
    rem = '0;
    quo = n;
    for (int i = 0; i < W; i++) begin
      tv = quo[W-1];
      quo = {quo[W-2:0], tFlag};
      runOp(3'b100, '0, '0, tv, "R8 load T");
      runOp(3'b011, rem, d, 1'b0, "R4 R5 R6 R7 step");
      rem = rnOut;
    end
    quo = {quo[W-2:0], tFlag};
    check("R5 R6 quotient", {quo, 3'b000}, {n / d, 3'b000});
  endtask

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'b001: return "R2 clear";
      3'b010: return "R3 signed setup";
      3'b011: return "R4 R5 R6 R7 step";
      3'b100: return "R8 load T";
      default: return "R9 idle code";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] n, d;
    logic [2:0] op;
    void'($urandom(32'h5EED_1234));
    // reset with a step request present
    opSel = 3'b011; rnIn = 32'hDEAD_BEEF; rmIn = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", {rnOut, qFlag, mFlag, tFlag}, '0);
    @(negedge clk);
    opSel = 3'b000;
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {rnOut, qFlag, mFlag, tFlag}, '0);

    // directed corners
    runOp(3'b010, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R3 signs 1/0");
    runOp(3'b011, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0, "R5 R6 add with carry");
    runOp(3'b010, 32'h0000_0001, 32'hF000_0000, 1'b0, "R3 signs 0/1");
    runOp(3'b010, 32'h8000_0001, 32'h8000_0000, 1'b0, "R3 signs 1/1");
    runOp(3'b011, 32'h0000_0000, 32'h0000_0001, 1'b0, "R5 R6 subtract with borrow");
    runOp(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 load T one");
    runOp(3'b111, 32'h1111_1111, 32'h2222_2222, 1'b0, "R9 code 7");
    runOp(3'b101, 32'h3333_3333, 32'h4444_4444, 1'b0, "R9 code 5");
    runOp(3'b110, 32'h5555_5555, 32'h6666_6666, 1'b1, "R9 code 6");
    runOp(3'b000, 32'h7777_7777, 32'h8888_8888, 1'b0, "R9 code 0");
    runOp(3'b001, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 1'b1, "R2 clear keeps rnOut");

    // divisions: corners then random
    divide(32'hFFFF_FFFF, 32'h0000_0001);
    divide(32'h0000_0000, 32'h0000_0007);
    divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    divide(32'h0000_0005, 32'h0000_0009);
    divide(32'h8000_0000, 32'h0000_0003);
    for (int k = 0; k < 40; k++) begin
      n = $urandom;
      d = $urandom;
      if (k % 3 == 0) d = d >> ($urandom % 31);
      if (d == 0) d = 32'd1;
      divide(n, d);
    end

    // random operation mix
    for (int k = 0; k < 300; k++) begin
      op = 3'($urandom % 8);
      runOp(op, $urandom, $urandom, 1'($urandom % 2), opTag(op));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule